// File: doc/BRIEF.md
# Dual-Edge Watchdog Timer

The block watches a heartbeat line from a processor and drives an active-low alarm line. The processor proves it is alive by toggling the heartbeat. A rising edge and a falling edge count the same, and either one restarts the timeout window. If the line stays at one level, high or low, for a full window, the alarm goes low. It stays low until the processor toggles the line again. Holding the line steady therefore cannot switch the watchdog off.

The system reset-asserted flag holds the timer cleared, so the timer does not count while reset is active. Counting starts on the first clock after reset is released. A separate supply-low flag pulls the alarm low directly, with no clock in the path. The alarm is released at once when the supply recovers, with no recovery delay.

A timeout does not reset anything by itself. Routing the alarm back into a manual reset input is done outside the block. The heartbeat is asynchronous to the clock, so it passes through a two-stage synchronizer before edge detection.

Top module: `dual_edge_wdt`

## Requirements
- R1: While `sys_rst_i` is high, the timer is cleared and no timeout is held, so `wdo_o` is 1 whenever `supply_low_i` is 0.
- R2: After `sys_rst_i` is released with no later heartbeat edge, `wdo_o` stays 1 through the first TIMEOUT_CYCLES-1 rising clock edges and is 0 after rising clock edge TIMEOUT_CYCLES.
- R3: A rising `wdi_i` transition that is first sampled at clock edge k restarts the timer at edge k+2. The next timeout drives `wdo_o` to 0 at edge k+2+TIMEOUT_CYCLES, and `wdo_o` is still 1 after edge k+1+TIMEOUT_CYCLES.
- R4: A falling `wdi_i` transition has exactly the same restart timing as a rising one (R3).
- R5: A constant `wdi_i` level, either 1 or 0, does not prevent the timeout.
- R6: Once a timeout is reached, `wdo_o` stays 0 for as long as no heartbeat edge arrives. The counter saturates and does not wrap. A transition first sampled at edge k returns `wdo_o` to 1 after edge k+2.
- R7: If a restart falls on the same clock edge as the terminal count, the restart wins. `wdo_o` stays 1 and a full new window begins.
- R8: `supply_low_i` = 1 forces `wdo_o` to 0 combinationally. When it returns to 0, `wdo_o` immediately shows the timeout state again: 1 if no timeout is held, 0 if one is.
- R9: Asserting `sys_rst_i` while a timeout is held clears it at once (`wdo_o` = 1). After release, a full window of TIMEOUT_CYCLES is needed before the next timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| wdi_i | input | 1 | Heartbeat from the processor, asynchronous; either edge restarts the window |
| sys_rst_i | input | 1 | System reset asserted, active high, asynchronous; holds the timer cleared |
| supply_low_i | input | 1 | Supply below threshold, active high; forces the alarm low |
| wdo_o | output | 1 | Watchdog alarm, active low |

## Verification
Directed runs first hold the heartbeat low and then high through a full window. This shows that a static level of either value times out, and it pins the exact expiry edge against the window length. Single rising and single falling transitions are placed against an already expired alarm, which separates the clearing delay from the restart delay. One transition is placed so that its restart lands exactly on the terminal count, which tells edge priority apart from expiry. Random stretches then mix dense, sparse and absent toggling with short supply dips and reset pulses. A per-cycle age model checks that every window boundary and every reset or supply interaction lands on the edge the requirements predict.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Width of a counter that must hold values 0 .. limit-1.
  function automatic int unsigned wdt_cnt_width(input int unsigned limit);
    int unsigned w;
    w = $clog2(limit);
    if (w < 1) w = 1;
    return w;
  endfunction

  // Terminal count test: the window is used up when count reaches limit-1.
  function automatic logic wdt_is_terminal(input logic [63:0] count,
                                           input int unsigned limit);
    return (count == 64'(limit - 1));
  endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic async_i,
  output logic level_o,
  output logic edge_o
);
  // Chain has STAGES synchronizer flops plus one history flop.
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] chain_q;

  // The chain is not reset: it keeps sampling during system reset so that
  // no false edge appears when reset is released.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i) chain_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i) chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign level_o = chain_q[STAGES-1];
  assign edge_o  = chain_q[STAGES-1] ^ chain_q[STAGES];
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned LIMIT = 40,
  parameter int unsigned CNT_W = wdt_cnt_width(LIMIT)
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             kick_i,
  output logic [CNT_W-1:0] count_o,
  output logic             terminal_o,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;
  logic             term_w;

  assign term_w = wdt_is_terminal(64'(cnt_q), LIMIT);

  // Priority: reset, then kick, then terminal (saturate and latch), then count.
  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (kick_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (term_w) begin
      exp_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign count_o    = cnt_q;
  assign terminal_o = term_w;
  assign expired_o  = exp_q;
endmodule

// File: rtl/wdt_out.sv
module wdt_out (
  input  logic expired_i,
  input  logic supply_low_i,
  output logic wdo_o
);
  // Active-low alarm. The supply path is purely combinational, so recovery
  // from a supply dip is immediate.
  assign wdo_o = ~(expired_i | supply_low_i);
endmodule

// File: rtl/dual_edge_wdt.sv
module dual_edge_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 80_000_000,
  parameter int unsigned SYNC_STAGES    = 2,
  localparam int unsigned CNT_W         = wdt_cnt_width(TIMEOUT_CYCLES)
) (
  input  logic clk_i,
  input  logic wdi_i,
  input  logic sys_rst_i,
  input  logic supply_low_i,
  output logic wdo_o
);
  // Named internal events, brought out for the bound checker.
  logic             wdi_level_w;
  logic             kick_w;
  logic [CNT_W-1:0] count_w;
  logic             terminal_w;
  logic             expired_w;

  wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .async_i (wdi_i),
    .level_o (wdi_level_w),
    .edge_o  (kick_w)
  );

  wdt_timer #(.LIMIT(TIMEOUT_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_i      (sys_rst_i),
    .kick_i     (kick_w),
    .count_o    (count_w),
    .terminal_o (terminal_w),
    .expired_o  (expired_w)
  );

  wdt_out u_out (
    .expired_i    (expired_w),
    .supply_low_i (supply_low_i),
    .wdo_o        (wdo_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             supply_low_i,
  input logic             wdo_i,
  input logic             kick_i,
  input logic             terminal_i,
  input logic             expired_i,
  input logic [CNT_W-1:0] count_i
);
  // R8: a low supply always holds the alarm low
  p_supply_forces_low_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    supply_low_i |-> !wdo_i);

  // R8: with the supply good, the alarm shows exactly the held timeout state
  p_supply_release_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !supply_low_i |-> (wdo_i == !expired_i));

  // R3 / R4: a detected edge restarts the window from zero
  p_kick_restarts_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    kick_i |=> (count_i == '0) && !expired_i);

  // R2: reaching the terminal count without a kick raises the timeout
  p_terminal_expires_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (terminal_i && !kick_i) |=> expired_i);

  // R6: the timeout holds and the count saturates until a kick
  p_hold_saturate_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (expired_i && !kick_i) |=> expired_i && $stable(count_i));

  // R7: a kick on the terminal cycle wins over expiry
  p_kick_priority_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (terminal_i && kick_i) |=> !expired_i);

  // R2: below the terminal count, each idle cycle advances the count by one
  p_counts_up_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!kick_i && !terminal_i) |=> count_i == CNT_W'($past(count_i) + 1'b1));
endmodule

bind dual_edge_wdt wdt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_i        (sys_rst_i),
  .supply_low_i (supply_low_i),
  .wdo_i        (wdo_o),
  .kick_i       (kick_w),
  .terminal_i   (terminal_w),
  .expired_i    (expired_w),
  .count_i      (count_w)
);

// File: tb/dual_edge_wdt_test.sv
`timescale 1ns/1ps
module dual_edge_wdt_test;
  localparam int unsigned T = 40;

  logic clk = 1'b0;
  logic wdi = 1'b0;
  logic sys_rst = 1'b1;
  logic supply_low = 1'b0;
  logic wdo;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_en = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;   // 50 MHz

  dual_edge_wdt #(.TIMEOUT_CYCLES(T)) uut (
    .clk_i        (clk),
    .wdi_i        (wdi),
    .sys_rst_i    (sys_rst),
    .supply_low_i (supply_low),
    .wdo_o        (wdo)
  );

  // Reference from the requirements: a heartbeat change seen at edge k counts
  // as a restart at edge k+2, and the alarm is low once at least T edges have
  // passed since the last restart or reset.
  logic h1 = 1'b0, h2 = 1'b0, h3 = 1'b0;
  int age = 0;

  function automatic logic expect_wdo(input int a, input logic low);
    return !(low || (a >= int'(T)));
  endfunction

  always @(posedge clk) begin
    h1 <= wdi;
    h2 <= h1;
    h3 <= h2;
    if (sys_rst)       age <= 0;
    else if (h2 != h3) age <= 0;
    else if (age < 1_000_000) age <= age + 1;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: wdo actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (cmp_en) chk(tag, wdo, expect_wdo(age, supply_low));
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int unsigned rv;
    rv = $urandom(32'd2024);

    // R1: reset holds the alarm high
    tick(5);
    chk("R1", wdo, 1'b1);
    cmp_en = 1'b1;
    tick(2);
    chk("R1", wdo, 1'b1);

    // R2 + R5 (static low): expiry exactly T edges after release
    tag = "R2";
    at_neg(); sys_rst = 1'b0;
    tick(T-1); chk("R2", wdo, 1'b1);
    tick(1);   chk("R2", wdo, 1'b0);
    tick(20);  chk("R5", wdo, 1'b0);

    // R6 clearing and R3 rising restart; R5 static high
    tag = "R3";
    at_neg(); wdi = 1'b1;
    tick(1); chk("R6", wdo, 1'b0);
    tick(1); chk("R6", wdo, 1'b0);
    tick(1); chk("R6", wdo, 1'b1);
    tick(T-1); chk("R3", wdo, 1'b1);
    tick(1);   chk("R3", wdo, 1'b0);
    tick(15);  chk("R5", wdo, 1'b0);

    // R4 falling restart
    tag = "R4";
    at_neg(); wdi = 1'b0;
    tick(2); chk("R4", wdo, 1'b0);
    tick(1); chk("R4", wdo, 1'b1);
    tick(T-1); chk("R4", wdo, 1'b1);
    tick(1);   chk("R4", wdo, 1'b0);

    // R7: restart lands exactly on the terminal count
    tag = "R7";
    at_neg(); wdi = 1'b1;
    tick(3); chk("R7", wdo, 1'b1);
    tick(T-3);
    at_neg(); wdi = 1'b0;
    tick(2); chk("R7", wdo, 1'b1);
    tick(1); chk("R7", wdo, 1'b1);
    tick(T-1); chk("R7", wdo, 1'b1);
    tick(1);   chk("R7", wdo, 1'b0);

    // R9: reset while expired clears it, then a full window is needed
    tag = "R9";
    at_neg(); sys_rst = 1'b1;
    #2 chk("R9", wdo, 1'b1);
    tick(3);
    at_neg(); sys_rst = 1'b0;
    tick(T-1); chk("R9", wdo, 1'b1);
    tick(1);   chk("R9", wdo, 1'b0);

    // R8: supply path is combinational in both directions
    tag = "R8";
    at_neg(); supply_low = 1'b1;
    #2 chk("R8", wdo, 1'b0);
    supply_low = 1'b0;
    #2 chk("R8", wdo, 1'b0);
    at_neg(); wdi = 1'b1;
    tick(3); chk("R8", wdo, 1'b1);
    at_neg(); supply_low = 1'b1;
    #2 chk("R8", wdo, 1'b0);
    supply_low = 1'b0;
    #2 chk("R8", wdo, 1'b1);

    // Random: dense, sparse and absent toggling with supply dips and resets
    tag = "R3";
    for (int seg = 0; seg < 4; seg++) begin
      int unsigned div;
      div = (seg == 0) ? 8 : (seg == 1) ? 45 : (seg == 2) ? 90 : 100000;
      for (int i = 0; i < 800; i++) begin
        at_neg();
        rv = $urandom;
        if (rv % div == 0) wdi = ~wdi;
        supply_low = ((rv >> 8) % 97 == 0);
        sys_rst = ((rv >> 16) % 331 == 0);
      end
    end
    at_neg(); sys_rst = 1'b0; supply_low = 1'b0;
    tick(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule